// File: doc/BRIEF.md
# Match and Capture Timer

A 32-bit counter for a peripheral bus. In timer mode it advances once every PRESCALE+1 clock cycles, with a free-running prescale counter setting the pace. In counter mode it advances on selected edges of one capture input, which then serves as the count clock. Four match channels compare the counter against programmable values. On a hit, each channel can flag an interrupt, zero the counter, or stop it.

Four capture channels latch the counter on a chosen edge of their inputs. All capture inputs pass through a two-flop synchronizer, and edges are detected in the clock domain. This means an external pulse is seen only if it lasts at least one clock period. Interrupt flags are collected in one register, which software clears by writing 1 to a flag. A single `irq` output is high whenever any flag is set.

Software controls the block through a word-addressed register interface. Writes take effect at the clock edge on which `bus_wr` is high. `bus_rdata` is registered and shows the register at `bus_addr` one clock later.

Top module: `match_capture_timer`

## Requirements
- R1: After `rst`, every register reads 0 and `irq` is low.
- R2: CTRL (address 1) bit 0 is RUN and bit 1 is HOLD. While HOLD is 1, the counter (address 2) and the prescale counter (address 4) are kept at 0. The counter changes only while RUN is 1, or when software writes address 2 directly.
- R3: MODE (address 7) bits [1:0] = 0 selects timer mode. In this mode the prescale counter rises by one each clock. When it reaches or exceeds PRESCALE (address 3), it returns to 0 and the counter advances by one, so the counter advances once every PRESCALE+1 clocks.
- R4: MODE bits [1:0] = 1, 2 or 3 selects counter mode. The counter then advances on rising edges, falling edges, or both edges of the capture input selected by MODE bits [3:2]. Edges on other inputs do not advance it, and the prescale counter stays at 0.
- R5: In counter mode, the capture inputs that are not the count source keep latching the counter as usual.
- R6: Match channel i (value at address 8+i) hits when the counter advances while it equals that value. MCTL (address 5) bit 3i set means that a hit raises flag i in FLAGS (address 0).
- R7: MCTL bit 3i+1 set means that a hit of channel i zeroes the counter instead of advancing it.
- R8: MCTL bit 3i+2 set means that a hit of channel i clears RUN and leaves the counter at the match value.
- R9: CCTL (address 6) bit 3i enables rising-edge capture and bit 3i+1 enables falling-edge capture for input i. Capture copies the counter into address 12+i, and an edge whose enable is 0 is ignored.
- R10: CCTL bit 3i+2 set means that a capture on input i raises FLAGS bit 4+i. `irq` is high in the cycle after any FLAGS bit is 1, and low in the cycle after FLAGS is 0.
- R11: Writing FLAGS clears exactly the bits written as 1. A flag that is raised in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| cap_in | input | 4 | Asynchronous capture / count inputs |
| irq | output | 1 | High while any interrupt flag is set |

## Verification
A match hit and a software write-1-clear can reach the same interrupt flag in the same clock. The bench provokes this by holding the counter at zero, starting it with a prescale of zero, and counting clocks so that the clear write lands exactly on the edge where the counter passes the match value. The flag must still read 1 afterwards. A later clear with no coincident hit must then drop it to 0.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int TW  = 32;

  localparam logic [AW-1:0] A_FLAGS = 4'd0;
  localparam logic [AW-1:0] A_CTRL  = 4'd1;
  localparam logic [AW-1:0] A_COUNT = 4'd2;
  localparam logic [AW-1:0] A_PRESC = 4'd3;
  localparam logic [AW-1:0] A_PCNT  = 4'd4;
  localparam logic [AW-1:0] A_MCTL  = 4'd5;
  localparam logic [AW-1:0] A_CCTL  = 4'd6;
  localparam logic [AW-1:0] A_MODE  = 4'd7;

  localparam logic [1:0] GRP_MATCH = 2'b10;
  localparam logic [1:0] GRP_CAP   = 2'b11;

  typedef enum logic [1:0] {
    CNT_TIMER = 2'b00,
    CNT_RISE  = 2'b01,
    CNT_FALL  = 2'b10,
    CNT_BOTH  = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], din[i]};
    end
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
    assign fall[i] = ~sh[STAGES-1] & sh[STAGES];
  end
endmodule

// File: rtl/mct_core.sv
module mct_core #(
  parameter int TW = 32,
  parameter int N  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold,
  input  logic                 run,
  input  logic                 timer_mode,
  input  logic                 ext_edge,
  input  logic [TW-1:0]        presc,
  input  logic                 cnt_wr,
  input  logic [TW-1:0]        cnt_wdata,
  input  logic [N-1:0][TW-1:0] match_val,
  input  logic [N-1:0]         act_rst,
  input  logic [N-1:0]         act_stop,
  output logic [TW-1:0]        tc,
  output logic [TW-1:0]        pc,
  output logic [N-1:0]         match_evt,
  output logic                 stop_req
);
  logic tick, any_rst, pc_wrap;

  assign pc_wrap = (pc >= presc);
  assign tick    = run & ~hold & (timer_mode ? pc_wrap : ext_edge);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_evt[i] = tick & (tc == match_val[i]);
  end

  assign any_rst  = |(match_evt & act_rst);
  assign stop_req = |(match_evt & act_stop);

  always_ff @(posedge clk) begin
    if (rst || hold)       tc <= '0;
    else if (cnt_wr)       tc <= cnt_wdata;
    else if (tick) begin
      if (any_rst)         tc <= '0;
      else if (!stop_req)  tc <= tc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold || !timer_mode) pc <= '0;
    else if (run)                   pc <= pc_wrap ? '0 : pc + 1'b1;
  end
endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer
  import mct_pkg::*;
#(
  parameter int TW = mct_pkg::TW,
  parameter int N  = mct_pkg::NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [TW-1:0] bus_wdata,
  output logic [TW-1:0] bus_rdata,
  input  logic [N-1:0]  cap_in,
  output logic          irq
);
  localparam int SW = $clog2(N);
  localparam int FW = 2 * N;

  logic                 run_q, hold_q;
  logic [TW-1:0]        presc_q;
  logic [3*N-1:0]       mctl_q, cctl_q;
  logic [SW+1:0]        mode_q;
  logic [N-1:0][TW-1:0] match_q, cap_q;
  logic [FW-1:0]        flags_q, flag_set, flag_clr;

  logic [TW-1:0] tc, pc;
  logic [N-1:0]  match_evt, cap_evt, rise, fall;
  logic [N-1:0]  act_int, act_rst, act_stop, cen_rise, cen_fall, cen_int;
  logic          stop_req, timer_mode, ext_edge, cnt_wr;
  logic [SW-1:0] src;

  for (genvar i = 0; i < N; i++) begin : g_fields
    assign act_int[i]  = mctl_q[3*i];
    assign act_rst[i]  = mctl_q[3*i+1];
    assign act_stop[i] = mctl_q[3*i+2];
    assign cen_rise[i] = cctl_q[3*i];
    assign cen_fall[i] = cctl_q[3*i+1];
    assign cen_int[i]  = cctl_q[3*i+2];
  end

  mct_edge_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(cap_in), .rise(rise), .fall(fall)
  );

  assign src        = mode_q[SW+1:2];
  assign timer_mode = (cnt_mode_e'(mode_q[1:0]) == CNT_TIMER);
  assign ext_edge   = (mode_q[0] & rise[src]) | (mode_q[1] & fall[src]);
  assign cnt_wr     = bus_wr && (bus_addr == A_COUNT);

  mct_core #(.TW(TW), .N(N)) u_core (
    .clk(clk), .rst(rst), .hold(hold_q), .run(run_q),
    .timer_mode(timer_mode), .ext_edge(ext_edge), .presc(presc_q),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata), .match_val(match_q),
    .act_rst(act_rst), .act_stop(act_stop),
    .tc(tc), .pc(pc), .match_evt(match_evt), .stop_req(stop_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; hold_q <= 1'b0; presc_q <= '0;
      mctl_q <= '0; cctl_q <= '0; mode_q <= '0; match_q <= '0;
    end else begin
      if (stop_req) run_q <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL:  begin run_q <= bus_wdata[0]; hold_q <= bus_wdata[1]; end
          A_PRESC: presc_q <= bus_wdata;
          A_MCTL:  mctl_q  <= bus_wdata[3*N-1:0];
          A_CCTL:  cctl_q  <= bus_wdata[3*N-1:0];
          A_MODE:  mode_q  <= bus_wdata[SW+1:0];
          default: if (bus_addr[3:2] == GRP_MATCH) match_q[bus_addr[SW-1:0]] <= bus_wdata;
        endcase
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cap
    assign cap_evt[i] = (rise[i] & cen_rise[i]) | (fall[i] & cen_fall[i]);
    always_ff @(posedge clk) begin
      if (rst)             cap_q[i] <= '0;
      else if (cap_evt[i]) cap_q[i] <= tc;
    end
  end

  assign flag_set = {cap_evt & cen_int, match_evt & act_int};
  assign flag_clr = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[FW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      irq     <= |flags_q;
    end
  end

  logic [TW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_FLAGS: rd_mux = TW'(flags_q);
      A_CTRL:  rd_mux = TW'({hold_q, run_q});
      A_COUNT: rd_mux = tc;
      A_PRESC: rd_mux = presc_q;
      A_PCNT:  rd_mux = pc;
      A_MCTL:  rd_mux = TW'(mctl_q);
      A_CCTL:  rd_mux = TW'(cctl_q);
      A_MODE:  rd_mux = TW'(mode_q);
      default: begin
        if (bus_addr[3:2] == GRP_MATCH) rd_mux = match_q[bus_addr[SW-1:0]];
        else                            rd_mux = cap_q[bus_addr[SW-1:0]];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int TW = 32,
  parameter int N  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic [3:0]      bus_addr,
  input logic [TW-1:0]   bus_wdata,
  input logic            hold_q,
  input logic            run_q,
  input logic            timer_mode,
  input logic [TW-1:0]   presc_q,
  input logic [TW-1:0]   tc,
  input logic [TW-1:0]   pc,
  input logic [2*N-1:0]  flags_q,
  input logic [2*N-1:0]  flag_set,
  input logic            irq,
  input logic [N-1:0]    match_evt,
  input logic [N-1:0]    act_rst,
  input logic [N-1:0]    act_stop
);
  logic wr_ctrl, wr_cnt, wr_flags;
  assign wr_ctrl  = bus_wr && bus_addr == 4'd1;
  assign wr_cnt   = bus_wr && bus_addr == 4'd2;
  assign wr_flags = bus_wr && bus_addr == 4'd0;

  p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (tc == '0 && pc == '0));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !hold_q && !wr_cnt) |=> $stable(tc));

  p_presc_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (run_q && !hold_q && timer_mode && pc >= presc_q) |=> pc == '0);

  p_match_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (|(match_evt & act_rst) && !hold_q && !wr_cnt) |=> tc == '0);

  p_match_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (|(match_evt & act_stop) && !wr_ctrl) |=> !run_q);

  p_irq_high_r10: assert property (@(posedge clk) disable iff (rst)
    (flags_q != '0) |=> irq);

  p_irq_low_r10: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0) |=> !irq);

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    wr_flags |=> ((flags_q & $past(bus_wdata[2*N-1:0] & ~flag_set)) == '0));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));
endmodule

bind match_capture_timer mct_checker #(.TW(TW), .N(N)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .hold_q(hold_q), .run_q(run_q),
  .timer_mode(timer_mode), .presc_q(presc_q), .tc(tc), .pc(pc),
  .flags_q(flags_q), .flag_set(flag_set), .irq(irq),
  .match_evt(match_evt), .act_rst(act_rst), .act_stop(act_stop)
);

// File: tb/match_capture_timer_test.sv
module match_capture_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_capture_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cap_in = '0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pulse(int idx, int hi, int lo);
    cap_in[idx] = 1'b1;
    repeat (hi) @(negedge clk);
    cap_in[idx] = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(4'd1, v);  chk("R1 ctrl", v, 0);
    rd(4'd2, v);  chk("R1 count", v, 0);
    rd(4'd0, v);  chk("R1 flags", v, 0);
    rd(4'd12, v); chk("R1 cap0", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    do_reset();
    wr(4'd1, 32'h3);
    repeat (10) @(negedge clk);
    rd(4'd2, v); chk("R2 hold count", v, 0);
    rd(4'd4, v); chk("R2 hold prescale", v, 0);
    wr(4'd1, 32'h0);
    repeat (5) @(negedge clk);
    rd(4'd2, v); chk("R2 stopped count", v, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    do_reset();
    wr(4'd3, 32'd2);
    wr(4'd1, 32'h1);
    repeat (29) @(negedge clk);
    wr(4'd1, 32'h0);
    rd(4'd2, v); chk("R3 prescale 2 count", v, 10);
    rd(4'd4, v); chk("R3 prescale wrapped", v, 0);
    wr(4'd1, 32'h2);
    wr(4'd3, 32'd0);
    wr(4'd1, 32'h1);
    repeat (9) @(negedge clk);
    wr(4'd1, 32'h0);
    rd(4'd2, v); chk("R3 prescale 0 count", v, 10);
  endtask

  task automatic t_match_reset();
    logic [31:0] v;
    do_reset();
    wr(4'd8, 32'd4);
    wr(4'd5, 32'h3);
    wr(4'd1, 32'h1);
    repeat (11) @(negedge clk);
    wr(4'd1, 32'h0);
    rd(4'd2, v); chk("R7 count wraps at match", v, 2);
    rd(4'd0, v); chk("R6 match flag", v, 32'h1);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    do_reset();
    wr(4'd9, 32'd7);
    wr(4'd5, 32'h20);
    wr(4'd1, 32'h1);
    repeat (20) @(negedge clk);
    rd(4'd2, v); chk("R8 count held at match", v, 7);
    rd(4'd1, v); chk("R8 run cleared", v, 0);
    rd(4'd0, v); chk("R6 no flag without int bit", v, 0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    do_reset();
    wr(4'd2, 32'h1234);
    wr(4'd6, 32'h405);
    pulse(0, 3, 5);
    rd(4'd12, v); chk("R9 rising capture", v, 32'h1234);
    rd(4'd0, v);  chk("R10 capture flag", v, 32'h10);
    chk("R10 irq high", {31'd0, irq}, 1);
    wr(4'd2, 32'h55);
    cap_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'd15, v); chk("R9 rising ignored on falling-only", v, 0);
    cap_in[3] = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'd15, v); chk("R9 falling capture", v, 32'h55);
    rd(4'd0, v);  chk("R10 no flag without int bit", v, 32'h10);
  endtask

  task automatic t_counter_mode();
    logic [31:0] v;
    do_reset();
    wr(4'd7, 32'h5);
    wr(4'd6, 32'h40);
    wr(4'd1, 32'h1);
    for (int k = 0; k < 5; k++) pulse(1, 2, 2);
    repeat (4) @(negedge clk);
    rd(4'd2, v); chk("R4 rising edge count", v, 5);
    rd(4'd4, v); chk("R4 prescale idle", v, 0);
    pulse(2, 2, 5);
    rd(4'd14, v); chk("R5 capture on other line", v, 5);
    pulse(0, 2, 5);
    rd(4'd2, v); chk("R4 other line ignored", v, 5);
    wr(4'd7, 32'h7);
    for (int k = 0; k < 3; k++) pulse(1, 2, 2);
    repeat (4) @(negedge clk);
    rd(4'd2, v); chk("R4 both edge count", v, 11);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    do_reset();
    wr(4'd6, 32'h2D);
    cap_in[1:0] = 2'b11;
    repeat (5) @(negedge clk);
    rd(4'd0, v); chk("R10 two capture flags", v, 32'h30);
    wr(4'd0, 32'h10);
    rd(4'd0, v); chk("R11 clear one flag", v, 32'h20);
    chk("R10 irq stays high", {31'd0, irq}, 1);
    wr(4'd0, 32'h20);
    repeat (2) @(negedge clk);
    rd(4'd0, v); chk("R11 clear last flag", v, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    do_reset();
    wr(4'd10, 32'd6);
    wr(4'd5, 32'h40);
    wr(4'd1, 32'h2);
    wr(4'd1, 32'h1);
    repeat (6) @(negedge clk);
    wr(4'd0, 32'h4);
    rd(4'd0, v); chk("R11 set wins over clear", v, 32'h4);
    wr(4'd0, 32'h4);
    rd(4'd0, v); chk("R11 plain clear", v, 0);
  endtask

  initial begin
    t_reset_state();
    t_hold();
    t_prescale();
    t_match_reset();
    t_stop();
    t_capture();
    t_counter_mode();
    t_clear();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule